// File: doc/BRIEF.md
# Dual-Port Inter-Processor Message Mailbox

The block is a mailbox that two processors, side A and side B, share. Each side reaches it through its own simple register port: an address, a write strobe with write data, and a read strobe whose data comes back one cycle later. There are eight one-way channels. Each channel has a four-entry FIFO of 32-bit messages and a direction bit that picks which side sends into it and which side drains it.

Each side has its own interrupt enable and interrupt status registers. A status word holds one receive flag and one transmit flag per channel. A receive flag is raised while the side's incoming FIFO holds data. It can be cleared only after that FIFO has been drained. Each side can read the other side's enable and status words. A sender therefore watches the receiver's receive flag fall to learn that its message was taken and acknowledged. Each side has one interrupt line, which is high while any enabled status flag is set.

Top module: `mbx_dual_mailbox`

## Requirements
- R1: After reset all FIFOs are empty, both enable words are 0, both interrupt lines and both read-data outputs are 0, and side A sends on every channel. The direction word at 0x00 therefore reads 0x10101010 from side A.
- R2: Byte address 0x00 covers channels 0-3 and 0x04 covers channels 4-7. For channel n, bit 8*(n%4) of the word reads 1 when the reading side receives on n, and bit 8*(n%4)+4 reads 1 when it sends. A write sets each channel of the addressed word so that the writer receives exactly when it wrote a 1 to that channel's receive bit; the transmit bits are ignored on a write. If both sides write in the same cycle, side A wins.
- R3: A write to 0x180+4n by the sending side pushes the 32-bit word. A read of 0x180+4n by the receiving side pops the oldest word, and that word appears on rdata in the next cycle. Words leave in the order they were pushed.
- R4: Each FIFO holds 4 words, and a push to a full FIFO is dropped. Bit 0 of 0x100+4n reads 1 exactly when channel n holds 4 words.
- R5: In a side's status word, bit 2n (the receive flag) is set while that side receives on channel n and the FIFO is not empty. Writing 1 to that bit at 0x70 clears it only once the FIFO is empty; otherwise the bit stays 1.
- R6: Bit 2n+1 (the transmit flag) is set while that side sends on channel n and the FIFO is not full. Writing 1 to it clears it, but it is set again the next cycle while that condition still holds.
- R7: 0x60 and 0x70 are the accessing side's own enable and status words. 0x40 and 0x50 return the other side's enable and status words and are read-only.
- R8: A side's interrupt output is 1 exactly when its enable AND its status is nonzero.
- R9: A data write by the receiving side is ignored. A data read by the sending side returns 0 and pops nothing. A data read of an empty FIFO returns 0 and leaves the count at 0.
- R10: Bits 2:0 of 0x140+4n give the number of words held in channel n, from 0 to 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| a_addr | input | 9 | Side A byte address |
| a_we | input | 1 | Side A write strobe |
| a_wdata | input | 32 | Side A write data |
| a_re | input | 1 | Side A read strobe |
| a_rdata | output | 32 | Side A read data, one cycle after a_re |
| irq_a | output | 1 | Side A interrupt |
| b_addr | input | 9 | Side B byte address |
| b_we | input | 1 | Side B write strobe |
| b_wdata | input | 32 | Side B write data |
| b_re | input | 1 | Side B read strobe |
| b_rdata | output | 32 | Side B read data, one cycle after b_re |
| irq_b | output | 1 | Side B interrupt |

## Verification
A corrupted FIFO pointer or count shows up at the ports one cycle after the next read of a data or count register, as a word out of order or a wrong count. A status flag that is lost or held shows on the interrupt line in the cycle after the write that caused it. It also shows on the other side's snoop read, so an acknowledge would arrive too early or never. A direction bit in the wrong state turns a push into a dropped write and turns a pop into a zero read. Every directed scenario therefore reads back counts, data and both status views right after each step.

// File: rtl/mbx_pkg.sv
`timescale 1ns/1ps
package mbx_pkg;

  typedef enum logic [3:0] {
    RG_NONE, RG_DIR, RG_PEER_EN, RG_PEER_ST, RG_OWN_EN, RG_OWN_ST,
    RG_FULL, RG_COUNT, RG_DATA
  } region_e;

  // Byte address to register region; the low address bits pick the channel.
  function automatic region_e decode_region(input logic [11:0] a);
    if (a[1:0] != 2'b00) return RG_NONE;
    if (a[11:3] == '0) return RG_DIR;
    case (a)
      12'h040: return RG_PEER_EN;
      12'h050: return RG_PEER_ST;
      12'h060: return RG_OWN_EN;
      12'h070: return RG_OWN_ST;
      default: ;
    endcase
    case (a[11:5])
      7'h08:   return RG_FULL;
      7'h0A:   return RG_COUNT;
      7'h0C:   return RG_DATA;
      default: ;
    endcase
    return RG_NONE;
  endfunction

  // Direction bit 0: side A sends. Direction bit 1: side B sends.
  function automatic logic sends(input logic dir_bit, input logic side);
    return dir_bit == side;
  endfunction

  function automatic logic receives(input logic dir_bit, input logic side);
    return dir_bit != side;
  endfunction

  // Direction word for four channels, as the given side sees it.
  function automatic logic [31:0] dir_word(input logic [3:0] d, input logic side);
    logic [31:0] w;
    w = '0;
    for (int k = 0; k < 4; k++) begin
      w[8*k]     = receives(d[k], side);
      w[8*k + 4] = sends(d[k], side);
    end
    return w;
  endfunction

endpackage

// File: rtl/mbx_chan_fifo.sv
`timescale 1ns/1ps
module mbx_chan_fifo #(
  parameter int unsigned DW    = 32,
  parameter int unsigned DEPTH = 4,
  localparam int unsigned PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [DW-1:0] din,
  input  logic          pop,
  output logic [DW-1:0] head,
  output logic [CW-1:0] cnt,
  output logic [CW-1:0] cnt_nxt,
  output logic          push_ok,
  output logic          pop_ok
);

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wp, rp;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign push_ok = push && (cnt != CW'(DEPTH));
  assign pop_ok  = pop && (cnt != '0);
  assign cnt_nxt = cnt + CW'(push_ok) - CW'(pop_ok);
  assign head    = mem[rp];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      if (push_ok) begin
        mem[wp] <= din;
        wp      <= bump(wp);
      end
      if (pop_ok) rp <= bump(rp);
      cnt <= cnt_nxt;
    end
  end

endmodule

// File: rtl/mbx_irq_bank.sv
`timescale 1ns/1ps
module mbx_irq_bank #(
  parameter int unsigned NCH = 8,
  localparam int unsigned IW = 2 * NCH
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] rx_cond,
  input  logic [NCH-1:0] tx_cond,
  input  logic           en_we,
  input  logic           clr_we,
  input  logic [IW-1:0]  wval,
  output logic [IW-1:0]  en,
  output logic [IW-1:0]  stat,
  output logic           irq
);

  logic [IW-1:0] set_v, clr_v, stat_nxt;

  always_comb begin
    for (int n = 0; n < NCH; n++) begin
      set_v[2*n]     = rx_cond[n];
      set_v[2*n + 1] = tx_cond[n];
    end
    clr_v    = clr_we ? wval : '0;
    stat_nxt = set_v | (stat & ~clr_v);
  end

  assign irq = |(en & stat);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en   <= '0;
      stat <= '0;
    end else begin
      if (en_we) en <= wval;
      stat <= stat_nxt;
    end
  end

endmodule

// File: rtl/mbx_dual_mailbox.sv
`timescale 1ns/1ps
module mbx_dual_mailbox #(
  parameter int unsigned NCH   = 8,
  parameter int unsigned DEPTH = 4,
  parameter int unsigned DW    = 32,
  parameter int unsigned AW    = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] a_addr,
  input  logic          a_we,
  input  logic [DW-1:0] a_wdata,
  input  logic          a_re,
  output logic [DW-1:0] a_rdata,
  output logic          irq_a,
  input  logic [AW-1:0] b_addr,
  input  logic          b_we,
  input  logic [DW-1:0] b_wdata,
  input  logic          b_re,
  output logic [DW-1:0] b_rdata,
  output logic          irq_b
);
  import mbx_pkg::*;

  localparam int unsigned CW = $clog2(DEPTH + 1);
  localparam int unsigned IW = 2 * NCH;
  localparam int unsigned XW = $clog2(NCH);

  logic [AW-1:0] addr_s  [2];
  logic          we_s    [2];
  logic          re_s    [2];
  logic [DW-1:0] wdata_s [2];
  region_e       rg      [2];
  logic [XW-1:0] ch_s    [2];
  logic [DW-1:0] rmux    [2];
  logic [DW-1:0] rdata_q [2];
  logic [NCH-1:0] dwr [2];
  logic [NCH-1:0] drd [2];
  logic [NCH-1:0] rx_cond [2];
  logic [NCH-1:0] tx_cond [2];

  logic [NCH-1:0]         dir, dir_nxt;
  logic [NCH-1:0][CW-1:0] cnt, cnt_nxt;
  logic [NCH-1:0][DW-1:0] head;
  logic [NCH-1:0]         push_req, pop_req, push_ok, pop_ok;
  logic [IW-1:0]          en_a, en_b, stat_a, stat_b;

  assign addr_s[0]  = a_addr;
  assign addr_s[1]  = b_addr;
  assign we_s[0]    = a_we;
  assign we_s[1]    = b_we;
  assign re_s[0]    = a_re;
  assign re_s[1]    = b_re;
  assign wdata_s[0] = a_wdata;
  assign wdata_s[1] = b_wdata;
  assign a_rdata    = rdata_q[0];
  assign b_rdata    = rdata_q[1];

  // Address decode, data strobes per channel and direction updates.
  always_comb begin
    for (int s = 0; s < 2; s++) begin
      rg[s]   = decode_region(12'(addr_s[s]));
      ch_s[s] = addr_s[s][2 +: XW];
      dwr[s]  = '0;
      drd[s]  = '0;
      if (we_s[s] && rg[s] == RG_DATA) dwr[s][ch_s[s]] = 1'b1;
      if (re_s[s] && rg[s] == RG_DATA) drd[s][ch_s[s]] = 1'b1;
    end
    dir_nxt = dir;
    for (int n = 0; n < NCH; n++) begin
      if (we_s[1] && rg[1] == RG_DIR && addr_s[1][2] == 1'(n / 4))
        dir_nxt[n] = ~wdata_s[1][8*(n%4)];
      if (we_s[0] && rg[0] == RG_DIR && addr_s[0][2] == 1'(n / 4))
        dir_nxt[n] = wdata_s[0][8*(n%4)];
    end
    for (int n = 0; n < NCH; n++) begin
      push_req[n] = dir[n] ? dwr[1][n] : dwr[0][n];
      pop_req[n]  = dir[n] ? drd[0][n] : drd[1][n];
    end
  end

  // Flag conditions follow the count as it will be after this cycle.
  always_comb begin
    for (int s = 0; s < 2; s++) begin
      for (int n = 0; n < NCH; n++) begin
        rx_cond[s][n] = receives(dir[n], 1'(s)) && (cnt_nxt[n] != '0);
        tx_cond[s][n] = sends(dir[n], 1'(s)) && (cnt_nxt[n] != CW'(DEPTH));
      end
    end
  end

  for (genvar n = 0; n < NCH; n++) begin : g_chan
    mbx_chan_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
      .clk     (clk),
      .rst_n   (rst_n),
      .push    (push_req[n]),
      .din     (dir[n] ? wdata_s[1] : wdata_s[0]),
      .pop     (pop_req[n]),
      .head    (head[n]),
      .cnt     (cnt[n]),
      .cnt_nxt (cnt_nxt[n]),
      .push_ok (push_ok[n]),
      .pop_ok  (pop_ok[n])
    );
  end

  mbx_irq_bank #(.NCH(NCH)) u_bank_a (
    .clk     (clk),
    .rst_n   (rst_n),
    .rx_cond (rx_cond[0]),
    .tx_cond (tx_cond[0]),
    .en_we   (we_s[0] && rg[0] == RG_OWN_EN),
    .clr_we  (we_s[0] && rg[0] == RG_OWN_ST),
    .wval    (wdata_s[0][IW-1:0]),
    .en      (en_a),
    .stat    (stat_a),
    .irq     (irq_a)
  );

  mbx_irq_bank #(.NCH(NCH)) u_bank_b (
    .clk     (clk),
    .rst_n   (rst_n),
    .rx_cond (rx_cond[1]),
    .tx_cond (tx_cond[1]),
    .en_we   (we_s[1] && rg[1] == RG_OWN_EN),
    .clr_we  (we_s[1] && rg[1] == RG_OWN_ST),
    .wval    (wdata_s[1][IW-1:0]),
    .en      (en_b),
    .stat    (stat_b),
    .irq     (irq_b)
  );

  // Read mux per side; the value is registered.
  always_comb begin
    for (int s = 0; s < 2; s++) begin
      rmux[s] = '0;
      unique case (rg[s])
        RG_DIR:     rmux[s] = DW'(dir_word(dir[{addr_s[s][2], 2'b00} +: 4], 1'(s)));
        RG_PEER_EN: rmux[s] = DW'((s == 0) ? en_b : en_a);
        RG_PEER_ST: rmux[s] = DW'((s == 0) ? stat_b : stat_a);
        RG_OWN_EN:  rmux[s] = DW'((s == 0) ? en_a : en_b);
        RG_OWN_ST:  rmux[s] = DW'((s == 0) ? stat_a : stat_b);
        RG_FULL:    rmux[s] = DW'(cnt[ch_s[s]] == CW'(DEPTH));
        RG_COUNT:   rmux[s] = DW'(cnt[ch_s[s]]);
        RG_DATA:
          if (receives(dir[ch_s[s]], 1'(s)) && cnt[ch_s[s]] != '0)
            rmux[s] = head[ch_s[s]];
        default:    rmux[s] = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dir <= '0;
      for (int s = 0; s < 2; s++) rdata_q[s] <= '0;
    end else begin
      dir <= dir_nxt;
      for (int s = 0; s < 2; s++) rdata_q[s] <= re_s[s] ? rmux[s] : '0;
    end
  end

endmodule

// File: rtl/mbx_dual_mailbox_chk.sv
`timescale 1ns/1ps
module mbx_dual_mailbox_chk #(
  parameter int unsigned NCH   = 8,
  parameter int unsigned DEPTH = 4,
  parameter int unsigned CW    = 3,
  parameter int unsigned IW    = 16
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [NCH-1:0]         dir,
  input logic [NCH-1:0][CW-1:0] cnt,
  input logic [NCH-1:0]         push_ok,
  input logic [NCH-1:0]         pop_ok,
  input logic [IW-1:0]          en_a,
  input logic [IW-1:0]          stat_a,
  input logic                   irq_a,
  input logic [IW-1:0]          en_b,
  input logic [IW-1:0]          stat_b,
  input logic                   irq_b
);

  for (genvar n = 0; n < NCH; n++) begin : g_chk
    // R4: the count never exceeds the depth
    a_r4_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
      cnt[n] <= CW'(DEPTH));
    // R4: a full FIFO without a pop stays full
    a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt[n] == CW'(DEPTH) && !pop_ok[n]) |=> cnt[n] == CW'(DEPTH));
    // R9: an empty FIFO without a push stays empty
    a_r9_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt[n] == '0 && !push_ok[n]) |=> cnt[n] == '0);
    // R5: a receive flag holds while data remains
    a_r5_rx_hold_a: assert property (@(posedge clk) disable iff (!rst_n)
      (dir[n] && stat_a[2*n] && cnt[n] != '0 && !pop_ok[n]) |=> stat_a[2*n]);
    a_r5_rx_hold_b: assert property (@(posedge clk) disable iff (!rst_n)
      (!dir[n] && stat_b[2*n] && cnt[n] != '0 && !pop_ok[n]) |=> stat_b[2*n]);
    // R6: a sender with room has its transmit flag set the next cycle
    a_r6_tx_set_a: assert property (@(posedge clk) disable iff (!rst_n)
      (!dir[n] && cnt[n] != CW'(DEPTH) && !push_ok[n]) |=> stat_a[2*n+1]);
  end

  // R8: an interrupt line is only high with an enabled flag set
  a_r8_irq_a: assert property (@(posedge clk) disable iff (!rst_n)
    irq_a |-> (en_a & stat_a) != '0);
  a_r8_irq_b: assert property (@(posedge clk) disable iff (!rst_n)
    irq_b |-> (en_b & stat_b) != '0);

endmodule

bind mbx_dual_mailbox mbx_dual_mailbox_chk #(
  .NCH(NCH), .DEPTH(DEPTH), .CW(CW), .IW(IW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .dir(dir), .cnt(cnt), .push_ok(push_ok),
  .pop_ok(pop_ok), .en_a(en_a), .stat_a(stat_a), .irq_a(irq_a),
  .en_b(en_b), .stat_b(stat_b), .irq_b(irq_b)
);

// File: tb/sim_mbx_dual_mailbox.sv
`timescale 1ns/1ps
module sim_mbx_dual_mailbox;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [8:0]  a_addr = '0, b_addr = '0;
  logic        a_we = 1'b0, b_we = 1'b0, a_re = 1'b0, b_re = 1'b0;
  logic [31:0] a_wdata = '0, b_wdata = '0;
  logic [31:0] a_rdata, b_rdata;
  logic        irq_a, irq_b;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  mbx_dual_mailbox u0 (
    .clk(clk), .rst_n(rst_n),
    .a_addr(a_addr), .a_we(a_we), .a_wdata(a_wdata), .a_re(a_re),
    .a_rdata(a_rdata), .irq_a(irq_a),
    .b_addr(b_addr), .b_we(b_we), .b_wdata(b_wdata), .b_re(b_re),
    .b_rdata(b_rdata), .irq_b(irq_b)
  );

  localparam bit SA = 1'b0;
  localparam bit SB = 1'b1;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input bit s, input logic [8:0] ad, input logic [31:0] d);
    @(negedge clk);
    if (s == SA) begin a_addr = ad; a_wdata = d; a_we = 1'b1; end
    else         begin b_addr = ad; b_wdata = d; b_we = 1'b1; end
    @(negedge clk);
    a_we = 1'b0;
    b_we = 1'b0;
  endtask

  task automatic rd(input bit s, input logic [8:0] ad, output logic [31:0] d);
    @(negedge clk);
    if (s == SA) begin a_addr = ad; a_re = 1'b1; end
    else         begin b_addr = ad; b_re = 1'b1; end
    @(negedge clk);
    a_re = 1'b0;
    b_re = 1'b0;
    d = (s == SA) ? a_rdata : b_rdata;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    check("R1 irq_a", {31'd0, irq_a}, 32'd0);
    check("R1 irq_b", {31'd0, irq_b}, 32'd0);
    check("R1 a_rdata", a_rdata, 32'd0);
    rd(SA, 9'h060, v); check("R1 own enable", v, 32'd0);
    rd(SA, 9'h140, v); check("R1 count ch0", v, 32'd0);
    rd(SA, 9'h000, v); check("R1 direction A", v, 32'h1010_1010);
  endtask

  task automatic t_direction;
    logic [31:0] v;
    wr(SA, 9'h000, 32'h0000_0100);          // A receives on channel 1
    rd(SA, 9'h000, v); check("R2 dir word A", v, 32'h1010_0110);
    rd(SB, 9'h000, v); check("R2 dir word B", v, 32'h0101_1001);
    wr(SB, 9'h004, 32'h0101_0101);          // B receives on 4..7: unchanged
    rd(SA, 9'h004, v); check("R2 dir word high", v, 32'h1010_1010);
  endtask

  task automatic t_order;
    logic [31:0] v;
    for (int i = 1; i <= 3; i++) wr(SA, 9'h180, 32'h1111_0000 + 32'(i));
    rd(SB, 9'h140, v); check("R10 count three", v, 32'd3);
    for (int i = 1; i <= 3; i++) begin
      rd(SB, 9'h180, v); check("R3 pop order", v, 32'h1111_0000 + 32'(i));
    end
    rd(SB, 9'h140, v); check("R10 count drained", v, 32'd0);
  endtask

  task automatic t_full;
    logic [31:0] v;
    for (int i = 0; i < 5; i++) wr(SA, 9'h188, 32'h20 + 32'(i));
    rd(SB, 9'h148, v); check("R4 count saturates", v, 32'd4);
    rd(SA, 9'h108, v); check("R4 full bit", v, 32'd1);
    for (int i = 0; i < 4; i++) begin
      rd(SB, 9'h188, v); check("R4 fifth push dropped", v, 32'h20 + 32'(i));
    end
    rd(SB, 9'h188, v); check("R9 empty pop", v, 32'd0);
    rd(SB, 9'h108, v); check("R4 full bit clear", v, 32'd0);
  endtask

  task automatic t_rx_ack;
    logic [31:0] v;
    wr(SB, 9'h070, 32'h1);                   // ch0 empty: clears
    wr(SB, 9'h060, 32'h1);
    check("R8 irq_b idle", {31'd0, irq_b}, 32'd0);
    wr(SA, 9'h180, 32'hA5);
    check("R5 irq_b on data", {31'd0, irq_b}, 32'd1);
    wr(SB, 9'h070, 32'h1);                   // data left: stays
    rd(SB, 9'h070, v); check("R5 clear blocked", v & 32'h1, 32'h1);
    rd(SA, 9'h050, v); check("R7 peer status pending", v & 32'h1, 32'h1);
    rd(SB, 9'h180, v); check("R3 pop value", v, 32'hA5);
    check("R5 sticky after drain", {31'd0, irq_b}, 32'd1);
    wr(SB, 9'h070, 32'h1);
    check("R5 cleared when empty", {31'd0, irq_b}, 32'd0);
    rd(SA, 9'h050, v); check("R7 peer status acked", v & 32'h1, 32'h0);
    rd(SA, 9'h040, v); check("R7 peer enable", v, 32'h1);
    wr(SA, 9'h040, 32'hFFFF);                // read-only from A
    rd(SB, 9'h060, v); check("R7 peer enable read-only", v, 32'h1);
    wr(SB, 9'h060, 32'h0);
  endtask

  task automatic t_tx;
    logic [31:0] v;
    wr(SA, 9'h070, 32'hFFFF);
    rd(SA, 9'h070, v); check("R6 tx reasserts", v, 32'h0000_AAA2);
    for (int i = 0; i < 4; i++) wr(SA, 9'h188, 32'h50 + 32'(i));
    wr(SA, 9'h070, 32'h20);
    rd(SA, 9'h070, v); check("R6 tx clear when full", v, 32'h0000_AA82);
    rd(SB, 9'h188, v); check("R3 pop after fill", v, 32'h50);
    rd(SA, 9'h070, v); check("R6 tx back with room", v, 32'h0000_AAA2);
    for (int i = 1; i < 4; i++) rd(SB, 9'h188, v);
  endtask

  task automatic t_ignore;
    logic [31:0] v;
    wr(SB, 9'h180, 32'hDEAD);
    rd(SB, 9'h140, v); check("R9 receiver write ignored", v, 32'd0);
    wr(SA, 9'h180, 32'h11);
    rd(SA, 9'h180, v); check("R9 sender read zero", v, 32'd0);
    rd(SB, 9'h140, v); check("R9 sender read no pop", v, 32'd1);
    rd(SB, 9'h180, v); check("R3 pop ch0", v, 32'h11);
    rd(SB, 9'h180, v); check("R9 empty read zero", v, 32'd0);
    rd(SB, 9'h140, v); check("R9 count stays zero", v, 32'd0);
    wr(SB, 9'h184, 32'h77);
    rd(SA, 9'h184, v); check("R2 reversed channel", v, 32'h77);
  endtask

  task automatic t_irq;
    logic [31:0] v;
    wr(SA, 9'h070, 32'h4);
    wr(SA, 9'h060, 32'h4);
    check("R8 irq_a masked idle", {31'd0, irq_a}, 32'd0);
    wr(SB, 9'h184, 32'h99);
    check("R8 irq_a on rx", {31'd0, irq_a}, 32'd1);
    rd(SA, 9'h184, v); check("R3 pop ch1", v, 32'h99);
    check("R8 irq_a sticky", {31'd0, irq_a}, 32'd1);
    wr(SA, 9'h070, 32'h4);
    check("R8 irq_a cleared", {31'd0, irq_a}, 32'd0);
    wr(SA, 9'h060, 32'h2);
    check("R8 irq_a on tx room", {31'd0, irq_a}, 32'd1);
    rd(SB, 9'h040, v); check("R7 peer enable of A", v, 32'h2);
    wr(SA, 9'h060, 32'h0);
    check("R8 irq_a disabled", {31'd0, irq_a}, 32'd0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_direction();
    t_order();
    t_full();
    t_rx_ack();
    t_tx();
    t_ignore();
    t_irq();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule